// File: doc/BRIEF.md
# Write-Only Inter-Chip Message Engine

This engine lets switch devices that share one bus pass frames to each other using posted writes only. No read exists on its bus side. Each write carries one message: a 3-bit type code, the 4-bit ID of the sending device and a 32-bit payload. When a local address is learned, the engine tells the other devices with a broadcast message. A device that wants to send a frame first asks the peer for a buffer. The peer does not answer with a read completion. It writes a start-of-packet message back, and that message carries the index of the buffer it has set aside. The sender then streams the data words and closes the frame with a byte count.

The same instance also serves the target side. Buffer requests from peers wait in a queue until the local buffer allocator offers a buffer, and each request is then answered with a start-of-packet write. Inbound data words and learned addresses are handed to local logic. An inbound end-of-packet is checked against the number of words that actually arrived. All outgoing messages share one write port, which is assumed to accept a write in every cycle. A fixed priority decides which source uses the port in a given cycle.

Top module: `wmsg_engine`

## Requirements
- R1: After reset, no write is issued, `tx_busy`, `buf_take` and every inbound pulse output are low.
- R2: Every write carries `wr_src` equal to `my_id` and one of these type codes: new address = 0, buffer request = 1, start of packet = 2, data transfer = 3, end of packet = 4.
- R3: A `tx_req` while idle raises `tx_busy` and issues a type-1 write to `tx_dst` whose payload is `tx_words`.
- R4: A type-2 message from the awaited peer causes `tx_words` type-3 writes to that peer, carrying `tx_data` in order (one word per `tx_data_rd` pulse). These are followed by a type-4 write whose payload is 4 × `tx_words`. The engine then gives one `tx_done` pulse with `tx_busy` low, and `tx_buf` holds the granted index.
- R5: If no matching type-2 message arrives within `tmo_limit` cycles of the request being sent, the engine gives one `tx_fail` pulse and returns to idle with no data written.
- R6: A `tx_req` while busy is ignored: no second buffer request is written until the current frame ends.
- R7: An inbound type-1 message is queued. While `buf_avail` is low the queue holds it and writes nothing. Once `buf_avail` is high, the queue answers in arrival order with a type-2 write to the requester, with payload `buf_idx` and one `buf_take` pulse per grant.
- R8: The write port is used by one source per cycle, with grants first, then new-address messages, then the local frame. A stalled message is sent unchanged later, and data order is kept.
- R9: A `learn_valid` pulse produces a type-0 write to broadcast ID 15, with payload `learn_addr`.
- R10: An inbound type-0 message gives, one cycle later, a `peer_learn_valid` pulse with its payload and source.
- R11: An inbound type-3 message gives, one cycle later, an `rx_data_valid` pulse with its payload and source.
- R12: An inbound type-4 message gives, one cycle later, `rx_eop_ok` if its payload equals 4 × the number of type-3 words received since the previous type-4 message, and `rx_eop_err` otherwise.
- R13: A type-2 message from a device other than the awaited peer, or one that arrives while no request is pending, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_id | input | 4 | This device's ID |
| tmo_limit | input | TMO_W | Number of cycles to wait for a buffer grant |
| tx_req | input | 1 | Start sending a local frame |
| tx_dst | input | 4 | Destination device of the frame |
| tx_words | input | LEN_W | Length of the frame in 32-bit words |
| tx_data | input | 32 | Current frame word |
| tx_data_rd | output | 1 | Current frame word has been sent |
| tx_busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | Pulse: frame complete |
| tx_fail | output | 1 | Pulse: buffer grant timed out |
| tx_buf | output | BUF_W | Buffer index granted by the peer |
| learn_valid | input | 1 | A local address was learned |
| learn_addr | input | 32 | Learned address tag |
| wr_valid | output | 1 | Write issued this cycle |
| wr_dst | output | 4 | Target device of the write |
| wr_type | output | 3 | Message type code |
| wr_src | output | 4 | Sender ID |
| wr_pay | output | 32 | Message payload |
| rx_valid | input | 1 | Inbound write present |
| rx_type | input | 3 | Inbound type code |
| rx_src | input | 4 | Inbound sender ID |
| rx_pay | input | 32 | Inbound payload |
| buf_avail | input | 1 | Allocator has a free buffer |
| buf_idx | input | BUF_W | Index of the free buffer |
| buf_take | output | 1 | Free buffer consumed |
| peer_learn_valid | output | 1 | Pulse: peer announced an address |
| peer_learn_addr | output | 32 | Announced address |
| peer_learn_src | output | 4 | Announcing device |
| rx_data_valid | output | 1 | Pulse: inbound data word |
| rx_data | output | 32 | Inbound data word |
| rx_data_src | output | 4 | Sender of the word |
| rx_eop_ok | output | 1 | Pulse: end of frame, count matches |
| rx_eop_err | output | 1 | Pulse: end of frame, count mismatch |

## Verification
The clash of interest is a buffer grant for a peer falling into a cycle in which the local frame has a data word ready to send. To provoke it, the bench answers the local request and then, while the words are still streaming, delivers a peer buffer request with a buffer available. It judges the outcome from the log of writes. The grant to the peer must sit between the first and last data words, and the data payloads must stay consecutive, with none lost or repeated.

// File: rtl/wme_pkg.sv
package wme_pkg;
    localparam int DEV_W = 4;
    localparam int PAY_W = 32;

    typedef enum logic [2:0] {
        MT_NEWADDR = 3'd0,
        MT_BUFREQ  = 3'd1,
        MT_SOP     = 3'd2,
        MT_XFER    = 3'd3,
        MT_EOP     = 3'd4
    } msg_t;

    typedef enum logic [2:0] {
        RQ_IDLE, RQ_REQ, RQ_WAIT, RQ_DATA, RQ_EOP
    } rq_st_t;

    localparam logic [DEV_W-1:0] BCAST_ID = '1;
endpackage

// File: rtl/wme_grant_q.sv
module wme_grant_q
    import wme_pkg::*;
#(
    parameter int QDEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DEV_W-1:0] push_src,
    input  logic             pop,
    output logic             head_valid,
    output logic [DEV_W-1:0] head_src
);
    localparam int AW = $clog2(QDEPTH);

    typedef struct packed {
        logic [QDEPTH-1:0][DEV_W-1:0] mem;
        logic [AW-1:0]                rp;
        logic [AW-1:0]                wp;
        logic [AW:0]                  cnt;
    } gq_t;

    gq_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (pop && q_q.cnt != '0) begin
            q_d.rp = q_q.rp + 1'b1;
        end
        if (push && q_q.cnt != (AW+1)'(QDEPTH)) begin
            q_d.mem[q_q.wp] = push_src;
            q_d.wp = q_q.wp + 1'b1;
        end
        case ({push && q_q.cnt != (AW+1)'(QDEPTH), pop && q_q.cnt != '0})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_valid = (q_q.cnt != '0);
    assign head_src   = q_q.mem[q_q.rp];
endmodule

// File: rtl/wme_requester.sv
module wme_requester
    import wme_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int TMO_W = 16,
    parameter int BUF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             req,
    input  logic [DEV_W-1:0] req_dst,
    input  logic [LEN_W-1:0] req_words,
    input  logic [PAY_W-1:0] data_in,
    input  logic             sop_valid,
    input  logic [DEV_W-1:0] sop_src,
    input  logic [BUF_W-1:0] sop_buf,
    input  logic             out_go,
    output logic             out_valid,
    output msg_t             out_type,
    output logic [DEV_W-1:0] out_dst,
    output logic [PAY_W-1:0] out_pay,
    output logic             data_rd,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [BUF_W-1:0] buf_o
);
    typedef struct packed {
        rq_st_t           st;
        logic [DEV_W-1:0] dst;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] left;
        logic [TMO_W-1:0] cnt;
        logic [BUF_W-1:0] bidx;
        logic             done;
        logic             fail;
    } rq_t;

    rq_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fail  = 1'b0;
        out_valid = 1'b0;
        out_type  = MT_BUFREQ;
        out_pay   = '0;
        data_rd   = 1'b0;
        case (r_q.st)
            RQ_IDLE: if (req) begin
                r_d.st  = RQ_REQ;
                r_d.dst = req_dst;
                r_d.len = req_words;
            end
            RQ_REQ: begin
                out_valid = 1'b1;
                out_pay   = PAY_W'(r_q.len);
                if (out_go) begin
                    r_d.st  = RQ_WAIT;
                    r_d.cnt = '0;
                end
            end
            RQ_WAIT: begin
                if (sop_valid && sop_src == r_q.dst) begin
                    r_d.bidx = sop_buf;
                    r_d.left = r_q.len;
                    r_d.st   = (r_q.len == '0) ? RQ_EOP : RQ_DATA;
                end else if (r_q.cnt == tmo_limit) begin
                    r_d.fail = 1'b1;
                    r_d.st   = RQ_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            RQ_DATA: begin
                out_valid = 1'b1;
                out_type  = MT_XFER;
                out_pay   = data_in;
                if (out_go) begin
                    data_rd  = 1'b1;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == LEN_W'(1)) r_d.st = RQ_EOP;
                end
            end
            RQ_EOP: begin
                out_valid = 1'b1;
                out_type  = MT_EOP;
                out_pay   = PAY_W'({r_q.len, 2'b00});
                if (out_go) begin
                    r_d.done = 1'b1;
                    r_d.st   = RQ_IDLE;
                end
            end
            default: r_d.st = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: RQ_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign out_dst = r_q.dst;
    assign busy    = (r_q.st != RQ_IDLE);
    assign done    = r_q.done;
    assign fail    = r_q.fail;
    assign buf_o   = r_q.bidx;
endmodule

// File: rtl/wme_rx_decode.sv
module wme_rx_decode
    import wme_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [2:0]       rx_type,
    input  logic [DEV_W-1:0] rx_src,
    input  logic [PAY_W-1:0] rx_pay,
    output logic             peer_v,
    output logic [PAY_W-1:0] peer_addr,
    output logic [DEV_W-1:0] peer_src,
    output logic             dat_v,
    output logic [PAY_W-1:0] dat,
    output logic [DEV_W-1:0] dat_src,
    output logic             eop_ok,
    output logic             eop_err
);
    typedef struct packed {
        logic             pv;
        logic [PAY_W-1:0] pa;
        logic [DEV_W-1:0] ps;
        logic             dv;
        logic [PAY_W-1:0] dw;
        logic [DEV_W-1:0] ds;
        logic             ok;
        logic             err;
        logic [CNT_W-1:0] words;
    } rd_t;

    rd_t s_q, s_d;

    always_comb begin
        s_d     = s_q;
        s_d.pv  = 1'b0;
        s_d.dv  = 1'b0;
        s_d.ok  = 1'b0;
        s_d.err = 1'b0;
        if (rx_valid) begin
            case (rx_type)
                MT_NEWADDR: begin
                    s_d.pv = 1'b1;
                    s_d.pa = rx_pay;
                    s_d.ps = rx_src;
                end
                MT_XFER: begin
                    s_d.dv    = 1'b1;
                    s_d.dw    = rx_pay;
                    s_d.ds    = rx_src;
                    s_d.words = s_q.words + 1'b1;
                end
                MT_EOP: begin
                    if (rx_pay == PAY_W'({s_q.words, 2'b00})) s_d.ok = 1'b1;
                    else                                      s_d.err = 1'b1;
                    s_d.words = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign peer_v    = s_q.pv;
    assign peer_addr = s_q.pa;
    assign peer_src  = s_q.ps;
    assign dat_v     = s_q.dv;
    assign dat       = s_q.dw;
    assign dat_src   = s_q.ds;
    assign eop_ok    = s_q.ok;
    assign eop_err   = s_q.err;
endmodule

// File: rtl/wmsg_engine.sv
module wmsg_engine
    import wme_pkg::*;
#(
    parameter int BUF_W  = 8,
    parameter int LEN_W  = 8,
    parameter int TMO_W  = 16,
    parameter int QDEPTH = 16,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       my_id,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             tx_req,
    input  logic [3:0]       tx_dst,
    input  logic [LEN_W-1:0] tx_words,
    input  logic [31:0]      tx_data,
    output logic             tx_data_rd,
    output logic             tx_busy,
    output logic             tx_done,
    output logic             tx_fail,
    output logic [BUF_W-1:0] tx_buf,
    input  logic             learn_valid,
    input  logic [31:0]      learn_addr,
    output logic             wr_valid,
    output logic [3:0]       wr_dst,
    output logic [2:0]       wr_type,
    output logic [3:0]       wr_src,
    output logic [31:0]      wr_pay,
    input  logic             rx_valid,
    input  logic [2:0]       rx_type,
    input  logic [3:0]       rx_src,
    input  logic [31:0]      rx_pay,
    input  logic             buf_avail,
    input  logic [BUF_W-1:0] buf_idx,
    output logic             buf_take,
    output logic             peer_learn_valid,
    output logic [31:0]      peer_learn_addr,
    output logic [3:0]       peer_learn_src,
    output logic             rx_data_valid,
    output logic [31:0]      rx_data,
    output logic [3:0]       rx_data_src,
    output logic             rx_eop_ok,
    output logic             rx_eop_err
);
    typedef struct packed {
        logic             pend;
        logic [PAY_W-1:0] addr;
    } lp_t;

    lp_t lp_q, lp_d;

    logic             gq_valid;
    logic [DEV_W-1:0] gq_src;
    logic             grant;
    logic             rq_valid, rq_go;
    msg_t             rq_type;
    logic [DEV_W-1:0] rq_dst;
    logic [PAY_W-1:0] rq_pay;
    logic             lp_send;

    assign grant   = gq_valid && buf_avail;
    assign lp_send = !grant && lp_q.pend;
    assign rq_go   = !grant && !lp_q.pend && rq_valid;

    wme_grant_q #(.QDEPTH(QDEPTH)) u_gq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_valid && rx_type == MT_BUFREQ),
        .push_src   (rx_src),
        .pop        (grant),
        .head_valid (gq_valid),
        .head_src   (gq_src)
    );

    wme_requester #(.LEN_W(LEN_W), .TMO_W(TMO_W), .BUF_W(BUF_W)) u_rq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_limit (tmo_limit),
        .req       (tx_req),
        .req_dst   (tx_dst),
        .req_words (tx_words),
        .data_in   (tx_data),
        .sop_valid (rx_valid && rx_type == MT_SOP),
        .sop_src   (rx_src),
        .sop_buf   (rx_pay[BUF_W-1:0]),
        .out_go    (rq_go),
        .out_valid (rq_valid),
        .out_type  (rq_type),
        .out_dst   (rq_dst),
        .out_pay   (rq_pay),
        .data_rd   (tx_data_rd),
        .busy      (tx_busy),
        .done      (tx_done),
        .fail      (tx_fail),
        .buf_o     (tx_buf)
    );

    wme_rx_decode #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_type   (rx_type),
        .rx_src    (rx_src),
        .rx_pay    (rx_pay),
        .peer_v    (peer_learn_valid),
        .peer_addr (peer_learn_addr),
        .peer_src  (peer_learn_src),
        .dat_v     (rx_data_valid),
        .dat       (rx_data),
        .dat_src   (rx_data_src),
        .eop_ok    (rx_eop_ok),
        .eop_err   (rx_eop_err)
    );

    always_comb begin
        lp_d = lp_q;
        if (lp_send)     lp_d.pend = 1'b0;
        if (learn_valid) lp_d = '{pend: 1'b1, addr: learn_addr};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lp_q <= '0;
        else        lp_q <= lp_d;
    end

    always_comb begin
        wr_valid = 1'b0;
        wr_dst   = '0;
        wr_type  = MT_NEWADDR;
        wr_pay   = '0;
        buf_take = 1'b0;
        if (grant) begin
            wr_valid = 1'b1;
            wr_dst   = gq_src;
            wr_type  = MT_SOP;
            wr_pay   = PAY_W'(buf_idx);
            buf_take = 1'b1;
        end else if (lp_q.pend) begin
            wr_valid = 1'b1;
            wr_dst   = BCAST_ID;
            wr_type  = MT_NEWADDR;
            wr_pay   = lp_q.addr;
        end else if (rq_valid) begin
            wr_valid = 1'b1;
            wr_dst   = rq_dst;
            wr_type  = rq_type;
            wr_pay   = rq_pay;
        end
    end

    assign wr_src = my_id;
endmodule

// File: rtl/wme_checker.sv
module wme_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] my_id,
    input logic       wr_valid,
    input logic [3:0] wr_dst,
    input logic [2:0] wr_type,
    input logic [3:0] wr_src,
    input logic       buf_take,
    input logic       buf_avail,
    input logic       tx_data_rd,
    input logic       tx_done,
    input logic       tx_fail,
    input logic       tx_busy,
    input logic       rx_eop_ok,
    input logic       rx_eop_err
);
    a_r2_legal_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_type <= 3'd4 && wr_src == my_id));

    a_r7_take_is_grant: assert property (@(posedge clk) disable iff (!rst_n)
        buf_take |-> (wr_valid && wr_type == 3'd2 && buf_avail));

    a_r9_newaddr_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_type == 3'd0) |-> wr_dst == 4'hF);

    a_r4_rd_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_data_rd |-> (wr_valid && wr_type == 3'd3));

    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_busy && !tx_fail));

    a_r6_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_type == 3'd1) |=> !(wr_valid && wr_type == 3'd1));

    a_r12_eop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_eop_ok && rx_eop_err));
endmodule

bind wmsg_engine wme_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .my_id      (my_id),
    .wr_valid   (wr_valid),
    .wr_dst     (wr_dst),
    .wr_type    (wr_type),
    .wr_src     (wr_src),
    .buf_take   (buf_take),
    .buf_avail  (buf_avail),
    .tx_data_rd (tx_data_rd),
    .tx_done    (tx_done),
    .tx_fail    (tx_fail),
    .tx_busy    (tx_busy),
    .rx_eop_ok  (rx_eop_ok),
    .rx_eop_err (rx_eop_err)
);

// File: tb/wmsg_engine_test.sv
module wmsg_engine_test;
    localparam int CLK_NS = 10;
    localparam int NV = 10;

    logic        clk = 0, rst_n = 0;
    logic [3:0]  my_id = 4'h9;
    logic [15:0] tmo_limit = 16'd100;
    logic        tx_req = 0;
    logic [3:0]  tx_dst = 0;
    logic [7:0]  tx_words = 0;
    logic [31:0] tx_data = 32'hA000_0000;
    logic        tx_data_rd, tx_busy, tx_done, tx_fail;
    logic [7:0]  tx_buf;
    logic        learn_valid = 0;
    logic [31:0] learn_addr = 0;
    logic        wr_valid;
    logic [3:0]  wr_dst, wr_src;
    logic [2:0]  wr_type;
    logic [31:0] wr_pay;
    logic        rx_valid = 0;
    logic [2:0]  rx_type = 0;
    logic [3:0]  rx_src = 0;
    logic [31:0] rx_pay = 0;
    logic        buf_avail = 0;
    logic [7:0]  buf_idx = 0;
    logic        buf_take;
    logic        peer_learn_valid, rx_data_valid, rx_eop_ok, rx_eop_err;
    logic [31:0] peer_learn_addr, rx_data;
    logic [3:0]  peer_learn_src, rx_data_src;

    wmsg_engine uut (.*);

    always #(CLK_NS/2) clk = ~clk;

    int nchk = 0, nerr = 0, wn = 0, ndone = 0, nfail = 0, ntake = 0;
    bit finished = 0;
    logic [2:0]  lt [0:255];
    logic [3:0]  ld [0:255];
    logic [3:0]  ls [0:255];
    logic [31:0] lpay [0:255];

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid && wn < 256) begin
                lt[wn] = wr_type; ld[wn] = wr_dst; ls[wn] = wr_src; lpay[wn] = wr_pay;
                wn++;
            end
            if (tx_done)  ndone++;
            if (tx_fail)  nfail++;
            if (buf_take) ntake++;
        end
    end

    always begin : data_src
        logic r;
        @(negedge clk);
        r = tx_data_rd;
        @(posedge clk);
        #1;
        if (r) tx_data = tx_data + 1;
    end

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_rx(input logic [2:0] t, input logic [3:0] s, input logic [31:0] p);
        rx_valid = 1; rx_type = t; rx_src = s; rx_pay = p;
        cyc();
        rx_valid = 0;
    endtask

    task automatic start_tx(input logic [3:0] d, input logic [7:0] w);
        tx_dst = d; tx_words = w; tx_req = 1;
        cyc();
        tx_req = 0;
    endtask

    task automatic find_log(input int from, input logic [2:0] t, output int idx);
        idx = -1;
        for (int k = 0; k < 300 && idx < 0; k++) begin
            @(negedge clk);
            for (int j = from; j < wn; j++) if (idx < 0 && lt[j] == t) idx = j;
        end
    endtask

    // inbound vectors: {type, src, payload, kind} kind 0 learn,1 data,2 ok,3 err
    localparam logic [40:0] VEC [NV] = '{
        {3'd0, 4'd2, 32'h1122_3344, 2'd0},
        {3'd3, 4'd3, 32'hDEAD_0001, 2'd1},
        {3'd3, 4'd3, 32'hDEAD_0002, 2'd1},
        {3'd4, 4'd3, 32'd8,         2'd2},
        {3'd4, 4'd3, 32'd4,         2'd3},
        {3'd3, 4'd4, 32'h0BAD_F00D, 2'd1},
        {3'd4, 4'd4, 32'd4,         2'd2},
        {3'd4, 4'd4, 32'd0,         2'd2},
        {3'd3, 4'd5, 32'h5555_AAAA, 2'd1},
        {3'd4, 4'd5, 32'd12,        2'd3}
    };

    initial begin : watchdog
        #(CLK_NS * 150000);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin : main
        int s0, i0, i1, ie, cycles;
        logic [31:0] base;
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!wr_valid && !tx_busy && !buf_take, "R1 idle after reset", {wr_valid, tx_busy, buf_take}, 0);
        chk(!peer_learn_valid && !rx_data_valid && !rx_eop_ok && !rx_eop_err, "R1 rx pulses low",
            {peer_learn_valid, rx_data_valid, rx_eop_ok, rx_eop_err}, 0);

        // inbound table: R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            logic [2:0] t; logic [3:0] s; logic [31:0] p; logic [1:0] k;
            {t, s, p, k} = VEC[v];
            send_rx(t, s, p);
            @(negedge clk);
            case (k)
                2'd0: chk(peer_learn_valid && peer_learn_addr == p && peer_learn_src == s,
                          "R10 peer learn", {peer_learn_valid, peer_learn_src, peer_learn_addr}, {1'b1, s, p});
                2'd1: chk(rx_data_valid && rx_data == p && rx_data_src == s,
                          "R11 rx data", {rx_data_valid, rx_data_src, rx_data}, {1'b1, s, p});
                2'd2: chk(rx_eop_ok && !rx_eop_err, "R12 eop match", {rx_eop_ok, rx_eop_err}, 2'b10);
                default: chk(!rx_eop_ok && rx_eop_err, "R12 eop mismatch", {rx_eop_ok, rx_eop_err}, 2'b01);
            endcase
        end

        // R13 stray SOP while idle
        s0 = wn;
        send_rx(3'd2, 4'd6, 32'h11);
        cyc(3);
        @(negedge clk);
        chk(!tx_busy && wn == s0 && ndone == 0, "R13 stray grant idle", {tx_busy, 8'(wn - s0)}, 0);

        // R3 R4 R6 R13 full handshake
        s0 = wn; base = tx_data;
        start_tx(4'd6, 8'd3);
        @(negedge clk);
        chk(tx_busy, "R3 busy after request", tx_busy, 1);
        find_log(s0, 3'd1, i0);
        chk(i0 >= 0 && ld[i0] == 4'd6 && lpay[i0] == 32'd3 && ls[i0] == 4'h9,
            "R3 buffer request", {ld[i0], lpay[i0]}, {4'd6, 32'd3});
        cyc();
        start_tx(4'd3, 8'd1);          // R6: ignored while busy
        send_rx(3'd2, 4'd5, 32'h77);  // R13: wrong peer
        cyc(2);
        @(negedge clk);
        chk(tx_busy && wn == i0 + 1, "R13 wrong-peer grant ignored", 8'(wn - i0), 1);
        send_rx(3'd2, 4'd6, 32'h2A);
        find_log(s0, 3'd4, ie);
        cyc(2);
        begin
            int nx = 0, nreq = 0; bit good = 1;
            for (int j = s0; j < wn; j++) begin
                if (lt[j] == 3'd1) nreq++;
                if (lt[j] == 3'd3) begin
                    if (lpay[j] != base + nx || ld[j] != 4'd6) good = 0;
                    nx++;
                end
            end
            chk(good && nx == 3, "R4 data words in order", nx, 3);
            chk(ie >= 0 && lpay[ie] == 32'd12, "R4 end byte count", lpay[ie], 12);
            chk(ndone == 1 && !tx_busy && tx_buf == 8'h2A, "R4 done and buffer", {ndone[3:0], tx_buf}, {4'd1, 8'h2A});
            chk(nreq == 1, "R6 one outstanding request", nreq, 1);
        end

        // R5 timeout
        tmo_limit = 16'd20;
        s0 = wn; cycles = 0;
        start_tx(4'd5, 8'd2);
        while (nfail == 0 && cycles < 200) begin @(negedge clk); cycles++; end
        begin
            int nx = 0;
            for (int j = s0; j < wn; j++) if (lt[j] == 3'd3) nx++;
            chk(nfail == 1 && cycles >= 20 && cycles <= 25, "R5 timeout window", cycles, 21);
            chk(nx == 0 && !tx_busy && ndone == 1, "R5 no data after timeout", nx, 0);
        end
        tmo_limit = 16'd100;

        // R7 queue while no buffer
        s0 = wn;
        send_rx(3'd1, 4'd1, 32'd4);
        send_rx(3'd1, 4'd2, 32'd4);
        send_rx(3'd1, 4'd3, 32'd4);
        cyc(4);
        @(negedge clk);
        chk(wn == s0 && ntake == 0, "R7 held without buffer", 8'(wn - s0), 0);
        buf_idx = 8'h55; buf_avail = 1;
        cyc(5);
        buf_avail = 0;
        @(negedge clk);
        chk(wn - s0 == 3 && ntake == 3, "R7 three grants", 8'(wn - s0), 3);
        chk(lt[s0] == 3'd2 && ld[s0] == 4'd1 && ld[s0+1] == 4'd2 && ld[s0+2] == 4'd3 && lpay[s0+2] == 32'h55,
            "R7 grant order", {ld[s0], ld[s0+1], ld[s0+2]}, 12'h123);

        // R9 learn broadcast
        s0 = wn;
        learn_addr = 32'hCAFE_BABE; learn_valid = 1;
        cyc();
        learn_valid = 0;
        find_log(s0, 3'd0, i0);
        chk(i0 >= 0 && ld[i0] == 4'hF && lpay[i0] == 32'hCAFE_BABE && ls[i0] == 4'h9,
            "R9 new address broadcast", {ld[i0], lpay[i0]}, {4'hF, 32'hCAFE_BABE});

        // R8 grant colliding with data stream
        s0 = wn; base = tx_data;
        buf_idx = 8'h66; buf_avail = 1;
        start_tx(4'd8, 8'd6);
        find_log(s0, 3'd1, i0);
        cyc();
        send_rx(3'd2, 4'd8, 32'h10);
        send_rx(3'd1, 4'd7, 32'd1);
        find_log(s0, 3'd4, ie);
        buf_avail = 0;
        cyc(2);
        begin
            int nx = 0, first = -1, last = -1, gi = -1; bit good = 1;
            for (int j = s0; j < wn; j++) begin
                if (lt[j] == 3'd3) begin
                    if (first < 0) first = j;
                    last = j;
                    if (lpay[j] != base + nx) good = 0;
                    nx++;
                end
                if (lt[j] == 3'd2 && ld[j] == 4'd7) gi = j;
            end
            i1 = gi;
            chk(good && nx == 6, "R8 data intact under grant", nx, 6);
            chk(i1 > first && i1 < last, "R8 grant inside data burst", i1, first + 1);
            chk(ie >= 0 && lpay[ie] == 32'd24 && ndone == 2, "R8 frame completes", lpay[ie], 24);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule